// File: doc/BRIEF.md
# USB Control Endpoint SETUP Capture

This block handles the SETUP stage on control endpoint 0 of a USB device. A received-packet front end gives it a start strobe, a data-PID flag, one byte per valid strobe, an end strobe and a CRC-error flag. The block gathers the eight request bytes in a shadow bank. It commits them to the visible request registers only when the packet proves clean. On commit it asks for an ACK handshake and, unless the request is SetAddress, pulses a SETUP-received status for firmware.

A committed SETUP overrides any NAK or STALL setting on endpoint 0. It forces both directions into NAK with STALL removed and the data toggle set, so the next data stage starts at DATA1. It also sets a protect flag. While that flag is up, firmware writes that would clear NAK are ignored. Firmware must first release the protect flag and then clear NAK for the direction it intends to use.

The controlling state machine has three states. IDLE goes to RECV on a start strobe while the bus is active. RECV goes back to IDLE when the active enable drops, or at an end strobe with a CRC error, the wrong data PID, or a byte count other than eight. RECV goes to COMMIT at a clean end. COMMIT always returns to IDLE after one cycle, and that cycle raises the ACK request.

Top module: `ep0_setup_capture`

## Requirements
- R1: A SETUP packet is accepted only while `usb_active` is 1. It is accepted whatever the current NAK and STALL flags are. With `usb_active` at 0, no ACK and no status are produced.
- R2: A clean packet is written to `setup_req`, with byte i at bits [8i+7:8i]. `hs_ack` is high for exactly one cycle: the cycle after the one in which `rx_end` is sampled.
- R3: `setup_rcvd` pulses together with `hs_ack` unless byte 0 is 0x00 and byte 1 is 0x05 (SetAddress). For SetAddress, `hs_ack` still pulses but `setup_rcvd` stays low.
- R4: A packet that ends with `rx_crc_err` high gives neither `hs_ack` nor `setup_rcvd`.
- R5: After a commit, `ep0_nak` is 2'b11 and `ep0_stall` is 2'b00. Bit 0 is the OUT direction and bit 1 is the IN direction.
- R6: After a commit, `ep0_toggle` is 2'b11.
- R7: After a commit, `ep0_protect` is 1. It returns to 0 only on `fw_prot_clr`.
- R8: While `ep0_protect` is 1, `fw_nak_clr` has no effect on either direction. This includes the cycle in which `fw_prot_clr` is also given.
- R9: A packet whose byte count is not 8, or whose data PID is DATA1 (`rx_pid_data1` = 1), is an error and gives no ACK and no status.
- R10: `setup_req` changes only on a commit. A failed packet leaves the earlier contents intact.
- R11: Without protection, firmware pulses act per direction. `fw_nak_set` sets NAK and beats `fw_nak_clr`, which clears it. `fw_stall_set` sets STALL and beats `fw_stall_clr`. `fw_tog_clr` clears the toggle. A commit in the same cycle beats all of them. All flags reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_active | input | 1 | Global enable for USB function |
| rx_start | input | 1 | Start of the data packet after a SETUP token to EP0 |
| rx_pid_data1 | input | 1 | Data PID of the packet is DATA1, valid with rx_start |
| rx_valid | input | 1 | rx_data holds a payload byte |
| rx_data | input | 8 | Payload byte |
| rx_end | input | 1 | End of packet |
| rx_crc_err | input | 1 | CRC failure, valid with rx_end |
| fw_prot_clr | input | 1 | Firmware releases the protect flag |
| fw_nak_set | input | 2 | Firmware sets NAK per direction |
| fw_nak_clr | input | 2 | Firmware clears NAK per direction |
| fw_stall_set | input | 2 | Firmware sets STALL per direction |
| fw_stall_clr | input | 2 | Firmware clears STALL per direction |
| fw_tog_clr | input | 2 | Firmware clears toggle per direction |
| setup_req | output | 64 | Committed request bytes |
| hs_ack | output | 1 | ACK handshake request |
| setup_rcvd | output | 1 | SETUP-received status pulse |
| ep0_nak | output | 2 | Force-NAK flags, bit 0 OUT, bit 1 IN |
| ep0_stall | output | 2 | Force-STALL flags |
| ep0_toggle | output | 2 | Data toggle flags |
| ep0_protect | output | 1 | Endpoint 0 protect flag |

## Verification
The assertions are checked on every cycle. They cover the flag state after each ACK (NAK on, STALL off, toggle and protect set), the single-cycle ACK, status only with ACK, silence while inactive, the request bank holding steady outside a commit, and NAK staying set while protected. Only the bench scenarios can show the following: that the right bytes land in the right positions, that SetAddress is told apart from other requests, and that each error kind (CRC, short, long, DATA1) suppresses the handshake. They also show that firmware pulses act with the stated priorities once protection is released.

// File: rtl/ep0_setup_pkg.sv
package ep0_setup_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_COMMIT
    } ep0_state_e;

    localparam int          DIR_OUT      = 0;
    localparam int          DIR_IN       = 1;
    localparam int          N_DIRS       = 2;
    localparam logic [7:0]  SETADDR_TYPE = 8'h00;
    localparam logic [7:0]  SETADDR_CODE = 8'h05;
endpackage

// File: rtl/ep0_setup_fsm.sv
module ep0_setup_fsm
    import ep0_setup_pkg::*;
#(
    parameter int REQ_BYTES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 usb_active,
    input  logic                 rx_start,
    input  logic                 rx_pid_data1,
    input  logic                 rx_valid,
    input  logic                 rx_end,
    input  logic                 rx_crc_err,
    output logic                 commit,
    output logic                 wr_en,
    output logic [$clog2(REQ_BYTES)-1:0] wr_idx
);
    localparam int CNT_W = $clog2(REQ_BYTES + 2);
    localparam int IDX_W = $clog2(REQ_BYTES);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(REQ_BYTES);
    localparam logic [CNT_W-1:0] OVER = CNT_W'(REQ_BYTES + 1);

    ep0_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             bad;

    // State register with byte counter and error latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            bad   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (rx_start && usb_active) begin
                        state <= S_RECV;
                        cnt   <= '0;
                        bad   <= rx_pid_data1;
                    end
                end
                S_RECV: begin
                    if (!usb_active) begin
                        state <= S_IDLE;
                    end else if (rx_end) begin
                        state <= (!rx_crc_err && !bad && cnt == FULL) ? S_COMMIT : S_IDLE;
                    end else if (rx_valid && cnt != OVER) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_COMMIT: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        commit = (state == S_COMMIT) && usb_active;
        wr_en  = (state == S_RECV) && rx_valid && !rx_end && (cnt < FULL);
        wr_idx = cnt[IDX_W-1:0];
    end
endmodule

// File: rtl/ep0_req_bank.sv
module ep0_req_bank
    import ep0_setup_pkg::*;
#(
    parameter int REQ_BYTES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(REQ_BYTES)-1:0] wr_idx,
    input  logic [7:0]                 wr_data,
    input  logic                       commit,
    output logic [8*REQ_BYTES-1:0]     req,
    output logic                       is_set_addr
);
    logic [7:0] shadow [REQ_BYTES];

    for (genvar i = 0; i < REQ_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow[i]        <= '0;
                req[8*i +: 8]    <= '0;
            end else begin
                if (wr_en && wr_idx == i[$clog2(REQ_BYTES)-1:0])
                    shadow[i] <= wr_data;
                if (commit)
                    req[8*i +: 8] <= shadow[i];
            end
        end
    end

    assign is_set_addr = (shadow[0] == SETADDR_TYPE) && (shadow[1] == SETADDR_CODE);
endmodule

// File: rtl/ep0_ctl_flags.sv
module ep0_ctl_flags
    import ep0_setup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              fw_prot_clr,
    input  logic [N_DIRS-1:0] fw_nak_set,
    input  logic [N_DIRS-1:0] fw_nak_clr,
    input  logic [N_DIRS-1:0] fw_stall_set,
    input  logic [N_DIRS-1:0] fw_stall_clr,
    input  logic [N_DIRS-1:0] fw_tog_clr,
    output logic [N_DIRS-1:0] nak,
    output logic [N_DIRS-1:0] stall,
    output logic [N_DIRS-1:0] tog,
    output logic              protect
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           protect <= 1'b0;
        else if (commit)      protect <= 1'b1;
        else if (fw_prot_clr) protect <= 1'b0;
    end

    for (genvar d = 0; d < N_DIRS; d++) begin : g_dir
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                nak[d]   <= 1'b0;
                stall[d] <= 1'b0;
                tog[d]   <= 1'b0;
            end else if (commit) begin
                nak[d]   <= 1'b1;
                stall[d] <= 1'b0;
                tog[d]   <= 1'b1;
            end else begin
                if (fw_nak_set[d])                 nak[d] <= 1'b1;
                else if (fw_nak_clr[d] && !protect) nak[d] <= 1'b0;
                if (fw_stall_set[d])               stall[d] <= 1'b1;
                else if (fw_stall_clr[d])          stall[d] <= 1'b0;
                if (fw_tog_clr[d])                 tog[d] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture
    import ep0_setup_pkg::*;
#(
    parameter int REQ_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   usb_active,
    input  logic                   rx_start,
    input  logic                   rx_pid_data1,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   rx_end,
    input  logic                   rx_crc_err,
    input  logic                   fw_prot_clr,
    input  logic [1:0]             fw_nak_set,
    input  logic [1:0]             fw_nak_clr,
    input  logic [1:0]             fw_stall_set,
    input  logic [1:0]             fw_stall_clr,
    input  logic [1:0]             fw_tog_clr,
    output logic [8*REQ_BYTES-1:0] setup_req,
    output logic                   hs_ack,
    output logic                   setup_rcvd,
    output logic [1:0]             ep0_nak,
    output logic [1:0]             ep0_stall,
    output logic [1:0]             ep0_toggle,
    output logic                   ep0_protect
);
    localparam int IDX_W = $clog2(REQ_BYTES);

    logic             commit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             is_set_addr;

    ep0_setup_fsm #(.REQ_BYTES(REQ_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .usb_active   (usb_active),
        .rx_start     (rx_start),
        .rx_pid_data1 (rx_pid_data1),
        .rx_valid     (rx_valid),
        .rx_end       (rx_end),
        .rx_crc_err   (rx_crc_err),
        .commit       (commit),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx)
    );

    ep0_req_bank #(.REQ_BYTES(REQ_BYTES)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (rx_data),
        .commit      (commit),
        .req         (setup_req),
        .is_set_addr (is_set_addr)
    );

    ep0_ctl_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .commit       (commit),
        .fw_prot_clr  (fw_prot_clr),
        .fw_nak_set   (fw_nak_set),
        .fw_nak_clr   (fw_nak_clr),
        .fw_stall_set (fw_stall_set),
        .fw_stall_clr (fw_stall_clr),
        .fw_tog_clr   (fw_tog_clr),
        .nak          (ep0_nak),
        .stall        (ep0_stall),
        .tog          (ep0_toggle),
        .protect      (ep0_protect)
    );

    assign hs_ack     = commit;
    assign setup_rcvd = commit && !is_set_addr;
endmodule

// File: rtl/ep0_setup_chk.sv
module ep0_setup_chk #(
    parameter int REQ_BYTES = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   usb_active,
    input logic                   hs_ack,
    input logic                   setup_rcvd,
    input logic [8*REQ_BYTES-1:0] setup_req,
    input logic [1:0]             ep0_nak,
    input logic [1:0]             ep0_stall,
    input logic [1:0]             ep0_toggle,
    input logic                   ep0_protect
);
    p_inactive_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !usb_active |-> !hs_ack);
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> !hs_ack);
    p_status_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        setup_rcvd |-> hs_ack);
    p_commit_nak_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> (ep0_nak == 2'b11 && ep0_stall == 2'b00));
    p_commit_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> ep0_toggle == 2'b11);
    p_commit_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> ep0_protect);
    p_nak_out_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_protect && ep0_nak[0]) |=> ep0_nak[0]);
    p_nak_in_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ep0_protect && ep0_nak[1]) |=> ep0_nak[1]);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_ack |=> $stable(setup_req));
endmodule

bind ep0_setup_capture ep0_setup_chk #(.REQ_BYTES(REQ_BYTES)) u_chk (.*);

// File: tb/sim_ep0_setup_capture.sv
`timescale 1ns/1ps
module sim_ep0_setup_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usb_active = 1'b0, rx_start = 1'b0, rx_pid_data1 = 1'b0;
    logic        rx_valid = 1'b0, rx_end = 1'b0, rx_crc_err = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        fw_prot_clr = 1'b0;
    logic [1:0]  fw_nak_set = '0, fw_nak_clr = '0, fw_stall_set = '0, fw_stall_clr = '0, fw_tog_clr = '0;
    logic [63:0] setup_req;
    logic        hs_ack, setup_rcvd, ep0_protect;
    logic [1:0]  ep0_nak, ep0_stall, ep0_toggle;

    always #2.5 clk = ~clk;

    ep0_setup_capture u0 (.*);

    int          errors = 0, checks = 0;
    bit          done = 0;
    logic [63:0] m_req = '0;
    logic [1:0]  m_nak = '0, m_stall = '0, m_tog = '0;
    logic        m_prot = 1'b0;
    logic [7:0]  pkt [10];

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic check_state(input string r);
        chk(r, setup_req, m_req);
        chk(r, {62'd0, ep0_nak}, {62'd0, m_nak});
        chk(r, {62'd0, ep0_stall}, {62'd0, m_stall});
        chk(r, {62'd0, ep0_toggle}, {62'd0, m_tog});
        chk(r, {63'd0, ep0_protect}, {63'd0, m_prot});
    endtask

    function automatic void fill_rand();
        for (int i = 0; i < 10; i++) pkt[i] = 8'($urandom);
    endfunction

    task automatic send(input int len, input bit d1, input bit crc, input bit act, input string r);
        bit ok, sa;
        ok = act && !crc && !d1 && (len == 8);
        sa = (pkt[0] == 8'h00) && (pkt[1] == 8'h05);
        usb_active = act; rx_start = 1'b1; rx_pid_data1 = d1;
        @(negedge clk);
        rx_start = 1'b0; rx_pid_data1 = 1'b0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_data = pkt[i];
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_end = 1'b1; rx_crc_err = crc;
        @(negedge clk);
        rx_end = 1'b0; rx_crc_err = 1'b0;
        chk({r, " ack"}, {63'd0, hs_ack}, {63'd0, ok});
        chk({r, " status R3"}, {63'd0, setup_rcvd}, {63'd0, ok && !sa});
        if (ok) begin
            for (int i = 0; i < 8; i++) m_req[8*i +: 8] = pkt[i];
            m_nak = 2'b11; m_stall = 2'b00; m_tog = 2'b11; m_prot = 1'b1;
        end
        @(negedge clk);
        usb_active = 1'b1;
        check_state({r, " R5/R6/R7/R10"});
    endtask

    task automatic fw(input bit pc, input logic [1:0] ns, input logic [1:0] nc,
                      input logic [1:0] ss, input logic [1:0] sc, input logic [1:0] tc,
                      input string r);
        fw_prot_clr = pc; fw_nak_set = ns; fw_nak_clr = nc;
        fw_stall_set = ss; fw_stall_clr = sc; fw_tog_clr = tc;
        for (int d = 0; d < 2; d++) begin
            if (ns[d]) m_nak[d] = 1'b1;
            else if (nc[d] && !m_prot) m_nak[d] = 1'b0;
            if (ss[d]) m_stall[d] = 1'b1;
            else if (sc[d]) m_stall[d] = 1'b0;
            if (tc[d]) m_tog[d] = 1'b0;
        end
        if (pc) m_prot = 1'b0;
        @(negedge clk);
        fw_prot_clr = 1'b0; fw_nak_set = '0; fw_nak_clr = '0;
        fw_stall_set = '0; fw_stall_clr = '0; fw_tog_clr = '0;
        check_state(r);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R11 reset");
        chk("R2 reset ack", {63'd0, hs_ack}, 64'd0);

        // R1: STALL and NAK set beforehand do not block a SETUP
        fw(1'b0, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00, "R11 set");
        fill_rand(); pkt[0] = 8'h80; pkt[1] = 8'h06;
        send(8, 1'b0, 1'b0, 1'b1, "R1 R2 override");
        // R8: clear NAK while protected is ignored
        fw(1'b0, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R8 blocked");
        fw(1'b1, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, "R8 same cycle");
        fw(1'b0, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10, "R11 out clr");
        fw(1'b0, 2'b10, 2'b10, 2'b01, 2'b00, 2'b01, "R11 prio");
        // R3: SetAddress
        fill_rand(); pkt[0] = 8'h00; pkt[1] = 8'h05;
        send(8, 1'b0, 1'b0, 1'b1, "R3 setaddr");
        // R4, R9, R10, R1 error cases
        fill_rand(); send(8, 1'b0, 1'b1, 1'b1, "R4 crc R10");
        fill_rand(); send(7, 1'b0, 1'b0, 1'b1, "R9 short R10");
        fill_rand(); send(9, 1'b0, 1'b0, 1'b1, "R9 long R10");
        fill_rand(); send(8, 1'b1, 1'b0, 1'b1, "R9 data1 R10");
        fill_rand(); send(8, 1'b0, 1'b0, 1'b0, "R1 inactive");
        fill_rand(); pkt[0] = 8'h00; pkt[1] = 8'h05;
        send(8, 1'b0, 1'b0, 1'b1, "R3 setaddr2");

        // Constrained random mix
        for (int it = 0; it < 60; it++) begin
            int len;
            bit d1, crc, act;
            fill_rand();
            if ($urandom_range(3) == 0) begin pkt[0] = 8'h00; pkt[1] = 8'h05; end
            len = ($urandom_range(3) == 0) ? int'($urandom_range(10)) : 8;
            d1  = ($urandom_range(5) == 0);
            crc = ($urandom_range(4) == 0);
            act = ($urandom_range(7) != 0);
            send(len, d1, crc, act, "R2 rand");
            fw(1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
               2'($urandom), 2'($urandom), "R11 rand");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule